// File: doc/BRIEF.md
# SPI Port Fault and Status Flag Logic

This block holds the status flags and error checks of an SPI port that can act as either master or slave. It sits beside the shifter and the receive buffer, and it watches four things: CPU register accesses, the shifter's busy signal, receive-buffer pushes, and the slave-select input. It keeps four sticky flags. Transfer done is set when the shifter finishes a transfer. Write collision is set by a data write while the shifter is busy; that write is not passed on. Overrun is set when a received byte arrives while the buffer is still full. Mode fault is set when another master drives slave-select low while this port is master.

A mode fault does two things. It drops the port to slave mode, and it holds every serial output-driver enable low until software clears the fault. Software clears a flag in two steps. First it reads the status register while the flag is set; this arms the flag. Then it makes a qualifying access, which clears it. The level interrupt is asserted when interrupts are enabled and either transfer done or mode fault is set.

Top module: `spi_fault_guard`

## Requirements
- R1: After reset all four flags are 0, master mode is off, the interrupt is low and all three driver enables are low.
- R2: A write to register address 0 loads master mode from wdata bit 0 and interrupt enable from wdata bit 1. `master_o` shows the master-mode bit.
- R3: A write to the data register (address 2) while `busy_i` is high does not raise `data_wr_accept_o` and sets the write-collision flag (bit 1) on the next edge. When idle, the write raises `data_wr_accept_o` in the same cycle and sets no flag.
- R4: While master mode is set, `ss_ni` low on two consecutive clock edges sets the mode-fault flag (bit 3) and clears master mode on the second edge. A single low sample, or any low level while in slave mode, sets nothing.
- R5: Driver enables depend on the mode. In master mode `mo_en_o` and `sck_en_o` are high and `so_en_o` is low. In slave mode `so_en_o` is high only while `ss_ni` is low. While mode fault is set, all three are low.
- R6: `rx_push_i` while `rx_full_i` is high sets the overrun flag (bit 2). A push into a buffer that is not full does not.
- R7: A `xfer_done_i` pulse sets the transfer-done flag (bit 0).
- R8: Transfer done, write collision and overrun are cleared by the following sequence: a status read (address 1) while the flag is set, then any read or write of the data register. A data access with no prior status read leaves them set.
- R9: Mode fault is cleared by a status read while it is set, followed by a control-register write. A data access does not clear it.
- R10: `irq_o` equals interrupt enable AND (transfer done OR mode fault). Write collision and overrun do not raise it.
- R11: If a flag's set event and its clearing access fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| ctrl_wdata_i | input | 2 | Control write data: bit0 master, bit1 irq enable |
| busy_i | input | 1 | Shifter transfer in progress |
| xfer_done_i | input | 1 | One-cycle pulse at transfer completion |
| rx_push_i | input | 1 | Received byte being delivered to buffer |
| rx_full_i | input | 1 | Receive buffer holds unread data / is full |
| ss_ni | input | 1 | Slave-select input, active low |
| data_wr_accept_o | output | 1 | Data write forwarded to the shifter |
| master_o | output | 1 | Master mode active |
| mo_en_o | output | 1 | Master data output driver enable |
| so_en_o | output | 1 | Slave data output driver enable |
| sck_en_o | output | 1 | Serial clock output driver enable |
| flags_o | output | 4 | {mode fault, overrun, write collision, transfer done} |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The hardest conditions to reach are the ordering cases of the two-step clear. One is a flag whose set event falls in the same cycle as its clearing access. Another is mode fault, which ignores a data access but yields to a control write. The stimulus arms each flag with a status read and then issues the clearing access. For the ordering case it pulses the set event in that same cycle. It checks that a data access made before any status read leaves the flag set, and it checks that a single-cycle low on slave select never trips the fault.

// File: rtl/spi_fault_pkg.sv
package spi_fault_pkg;
  localparam int unsigned NFLAGS   = 4;
  localparam int unsigned F_DONE   = 0;
  localparam int unsigned F_WCOL   = 1;
  localparam int unsigned F_OVR    = 2;
  localparam int unsigned F_MODF   = 3;
  localparam int unsigned ADDR_W   = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;
  localparam int unsigned CB_MASTER = 0;
  localparam int unsigned CB_IRQEN  = 1;
  localparam int unsigned CTRL_W    = 2;
endpackage

// File: rtl/spi_flag_cell.sv
module spi_flag_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic arm_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (set_i) begin
      flag_q  <= 1'b1;
      armed_q <= 1'b0; // new event needs a fresh status read
    end else if (armed_q && clr_i) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (arm_i && flag_q) begin
      armed_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/spi_modf_filter.sv
module spi_modf_filter #(
  parameter int unsigned SAMPLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic master_i,
  input  logic ss_ni,
  output logic fault_o
);
  localparam int unsigned CNT_W = $clog2(SAMPLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             low;

  assign low     = master_i && !ss_ni;
  assign fault_o = low && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!low)         cnt_q <= '0;
    else if (cnt_q < LAST) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_fault_guard.sv
module spi_fault_guard
  import spi_fault_pkg::*;
#(
  parameter int unsigned MODF_SAMPLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              busy_i,
  input  logic              xfer_done_i,
  input  logic              rx_push_i,
  input  logic              rx_full_i,
  input  logic              ss_ni,
  output logic              data_wr_accept_o,
  output logic              master_o,
  output logic              mo_en_o,
  output logic              so_en_o,
  output logic              sck_en_o,
  output logic [NFLAGS-1:0] flags_o,
  output logic              irq_o
);
  logic ctrl_wr, stat_rd, data_wr, data_acc;
  logic master_q, irq_en_q, modf_evt;
  logic [NFLAGS-1:0] set_v, clr_v;

  assign ctrl_wr  = reg_wr_i && (reg_addr_i == A_CTRL);
  assign stat_rd  = reg_rd_i && (reg_addr_i == A_STAT);
  assign data_wr  = reg_wr_i && (reg_addr_i == A_DATA);
  assign data_acc = (reg_wr_i || reg_rd_i) && (reg_addr_i == A_DATA);

  spi_modf_filter #(.SAMPLES(MODF_SAMPLES)) u_modf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .master_i(master_q),
    .ss_ni   (ss_ni),
    .fault_o (modf_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (modf_evt)     master_q <= 1'b0;
      else if (ctrl_wr) master_q <= ctrl_wdata_i[CB_MASTER];
      if (ctrl_wr)      irq_en_q <= ctrl_wdata_i[CB_IRQEN];
    end
  end

  always_comb begin
    set_v         = '0;
    set_v[F_DONE] = xfer_done_i;
    set_v[F_WCOL] = data_wr && busy_i;
    set_v[F_OVR]  = rx_push_i && rx_full_i;
    set_v[F_MODF] = modf_evt;
  end

  for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
    if (g == F_MODF) begin : g_ctrl_clr
      assign clr_v[g] = ctrl_wr;
    end else begin : g_data_clr
      assign clr_v[g] = data_acc;
    end
    spi_flag_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (set_v[g]),
      .arm_i (stat_rd),
      .clr_i (clr_v[g]),
      .flag_o(flags_o[g])
    );
  end

  assign data_wr_accept_o = data_wr && !busy_i;
  assign master_o = master_q;
  assign mo_en_o  = master_q && !flags_o[F_MODF];
  assign sck_en_o = master_q && !flags_o[F_MODF];
  assign so_en_o  = !master_q && !ss_ni && !flags_o[F_MODF];
  assign irq_o    = irq_en_q && (flags_o[F_DONE] || flags_o[F_MODF]);
endmodule

// File: rtl/spi_fault_guard_chk.sv
module spi_fault_guard_chk
  import spi_fault_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [CTRL_W-1:0] ctrl_wdata_i,
  input logic              busy_i,
  input logic              xfer_done_i,
  input logic              rx_push_i,
  input logic              rx_full_i,
  input logic              ss_ni,
  input logic              data_wr_accept_o,
  input logic              master_o,
  input logic              mo_en_o,
  input logic              so_en_o,
  input logic              sck_en_o,
  input logic [NFLAGS-1:0] flags_o,
  input logic              irq_o
);
  logic c_dwr, c_dacc, c_cwr;
  assign c_dwr  = reg_wr_i && reg_addr_i == A_DATA;
  assign c_dacc = (reg_wr_i || reg_rd_i) && reg_addr_i == A_DATA;
  assign c_cwr  = reg_wr_i && reg_addr_i == A_CTRL;

  assert_wcol_discard_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_dwr && busy_i) |-> !data_wr_accept_o);
  assert_wcol_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_dwr && busy_i) |=> flags_o[F_WCOL]);
  assert_ctrl_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_cwr && ss_ni) |=> (master_o == $past(ctrl_wdata_i[CB_MASTER])));
  assert_modf_detect_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_o && !ss_ni && $past(master_o) && !$past(ss_ni)) |=> (flags_o[F_MODF] && !master_o));
  assert_drv_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[F_MODF] |-> !(mo_en_o || so_en_o || sck_en_o));
  assert_ovr_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && rx_full_i) |=> flags_o[F_OVR]);
  assert_done_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i |=> flags_o[F_DONE]);
  assert_done_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags_o[F_DONE]) |-> $past(c_dacc));
  assert_modf_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flags_o[F_MODF]) |-> $past(c_cwr));
  assert_irq_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flags_o[F_DONE] || flags_o[F_MODF]));
endmodule

bind spi_fault_guard spi_fault_guard_chk u_chk (.*);

// File: tb/test_spi_fault_guard.sv
`timescale 1ns/1ps
module test_spi_fault_guard;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] reg_addr_i = '0;
  logic       reg_wr_i = 0, reg_rd_i = 0;
  logic [1:0] ctrl_wdata_i = '0;
  logic       busy_i = 0, xfer_done_i = 0, rx_push_i = 0, rx_full_i = 0;
  logic       ss_ni = 1'b1;
  logic       data_wr_accept_o, master_o, mo_en_o, so_en_o, sck_en_o, irq_o;
  logic [3:0] flags_o;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  spi_fault_guard i_spi_fault_guard (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one register access spanning one rising edge
  task automatic acc(input logic [1:0] a, input logic wr, input logic rd, input logic [1:0] wd);
    reg_addr_i = a; reg_wr_i = wr; reg_rd_i = rd; ctrl_wdata_i = wd;
    @(negedge clk_i);
    reg_wr_i = 0; reg_rd_i = 0;
  endtask

  task automatic clear_all();
    acc(2'd1, 0, 1, 2'b00);
    acc(2'd2, 0, 1, 2'b00);
  endtask

  task automatic t_reset();
    chk("R1 flags", {4'h0, flags_o}, 8'h0);
    chk("R1 master/irq/drv", {3'b0, master_o, irq_o, mo_en_o, so_en_o, sck_en_o}, 8'h0);
  endtask

  task automatic t_ctrl();
    acc(2'd0, 1, 0, 2'b01);
    chk("R2 master set", {7'b0, master_o}, 8'h1);
    chk("R5 master drivers", {5'b0, mo_en_o, so_en_o, sck_en_o}, 8'b101);
    acc(2'd0, 1, 0, 2'b00);
    chk("R2 master off", {7'b0, master_o}, 8'h0);
    ss_ni = 0; #1;
    chk("R5 slave selected so_en", {5'b0, mo_en_o, so_en_o, sck_en_o}, 8'b010);
    ss_ni = 1; #1;
    chk("R5 slave deselected", {5'b0, mo_en_o, so_en_o, sck_en_o}, 8'b000);
  endtask

  task automatic t_wcol();
    busy_i = 0; reg_addr_i = 2'd2; reg_wr_i = 1; #1;
    chk("R3 idle accept", {7'b0, data_wr_accept_o}, 8'h1);
    @(negedge clk_i); reg_wr_i = 0;
    chk("R3 idle no wcol", {7'b0, flags_o[1]}, 8'h0);
    busy_i = 1; reg_addr_i = 2'd2; reg_wr_i = 1; #1;
    chk("R3 busy discard", {7'b0, data_wr_accept_o}, 8'h0);
    @(negedge clk_i); reg_wr_i = 0; busy_i = 0;
    chk("R3 wcol set", {7'b0, flags_o[1]}, 8'h1);
    acc(2'd2, 0, 1, 2'b00);
    chk("R8 no clear without status read", {7'b0, flags_o[1]}, 8'h1);
    acc(2'd1, 0, 1, 2'b00);
    chk("R8 armed still set", {7'b0, flags_o[1]}, 8'h1);
    acc(2'd2, 0, 1, 2'b00);
    chk("R8 wcol cleared", {7'b0, flags_o[1]}, 8'h0);
  endtask

  task automatic t_ovr();
    rx_push_i = 1; rx_full_i = 0; @(negedge clk_i); rx_push_i = 0;
    chk("R6 push not full", {7'b0, flags_o[2]}, 8'h0);
    rx_push_i = 1; rx_full_i = 1; @(negedge clk_i); rx_push_i = 0; rx_full_i = 0;
    chk("R6 overrun set", {7'b0, flags_o[2]}, 8'h1);
    chk("R10 overrun no irq", {7'b0, irq_o}, 8'h0);
    clear_all();
    chk("R8 overrun cleared", {7'b0, flags_o[2]}, 8'h0);
  endtask

  task automatic t_done_irq();
    acc(2'd0, 1, 0, 2'b10);
    xfer_done_i = 1; @(negedge clk_i); xfer_done_i = 0;
    chk("R7 done set", {7'b0, flags_o[0]}, 8'h1);
    chk("R10 irq on done", {7'b0, irq_o}, 8'h1);
    acc(2'd1, 0, 1, 2'b00);
    reg_addr_i = 2'd2; reg_rd_i = 1; xfer_done_i = 1;
    @(negedge clk_i); reg_rd_i = 0; xfer_done_i = 0;
    chk("R11 set wins over clear", {7'b0, flags_o[0]}, 8'h1);
    clear_all();
    chk("R8 done cleared", {7'b0, flags_o[0]}, 8'h0);
    chk("R10 irq drops", {7'b0, irq_o}, 8'h0);
    busy_i = 1; acc(2'd2, 1, 0, 2'b00); busy_i = 0;
    chk("R10 wcol no irq", {7'b0, irq_o}, 8'h0);
    clear_all();
  endtask

  task automatic t_modf();
    ss_ni = 0; @(negedge clk_i); @(negedge clk_i); ss_ni = 1;
    chk("R4 slave mode no fault", {7'b0, flags_o[3]}, 8'h0);
    acc(2'd0, 1, 0, 2'b11);
    ss_ni = 0; @(negedge clk_i); ss_ni = 1; @(negedge clk_i);
    chk("R4 single low no fault", {6'b0, flags_o[3], master_o}, 8'b01);
    ss_ni = 0; @(negedge clk_i); @(negedge clk_i); ss_ni = 1;
    chk("R4 fault set master cleared", {6'b0, flags_o[3], master_o}, 8'b10);
    chk("R5 drivers off", {5'b0, mo_en_o, so_en_o, sck_en_o}, 8'h0);
    ss_ni = 0; #1;
    chk("R5 so_en held off", {7'b0, so_en_o}, 8'h0);
    ss_ni = 1;
    chk("R10 irq on modf", {7'b0, irq_o}, 8'h1);
    acc(2'd1, 0, 1, 2'b00);
    acc(2'd2, 0, 1, 2'b00);
    chk("R9 data access keeps modf", {7'b0, flags_o[3]}, 8'h1);
    acc(2'd0, 1, 0, 2'b01);
    chk("R9 modf cleared", {6'b0, flags_o[3], master_o}, 8'b01);
    chk("R5 drivers back", {5'b0, mo_en_o, so_en_o, sck_en_o}, 8'b101);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    rst_ni = 1;
    @(negedge clk_i);
    t_ctrl();
    t_wcol();
    t_ovr();
    t_done_irq();
    t_modf();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule